// File: doc/BRIEF.md
# Dual-Channel Disk Interrupt Status Aggregator

This block holds the interrupt status of a two-channel disk controller inside its configuration space. Each channel raises a level interrupt line; the block turns each edge of that line into a pending flag, keeps the flag visible in two configuration bytes at once, and merges both channels into one level-sensitive interrupt output. Each channel also has a block mask. A masked channel keeps its pending flag, but that flag does not reach the output.

Software clears a pending flag by writing a one to it. It may write through either of the two bytes that show the flag. Each flag is stored once, as the state of a small per-channel machine with two states: `CH_IDLE` (no interrupt pending) and `CH_PEND` (interrupt pending). Both bytes read that single state, so the two copies can never disagree. The machine has these transitions:
- `CH_IDLE -> CH_PEND` on a rising edge of the channel line (SET).
- `CH_PEND -> CH_IDLE` on a falling edge of the line (DROP).
- `CH_PEND -> CH_IDLE` on a write-one-to-clear with no rising edge in the same cycle (CLEAR).
- Every other case keeps the current state (HOLD). A rising edge in the same cycle as a clear counts as SET.

The block masks are loaded through a separate two-bit mask port, which stands for the bus-master register window. On the configuration port the mask bits are read-only.

Top module: `irq_status_agg`

## Requirements
- R1: A synchronous active-high `rst` returns both channels to `CH_IDLE` and clears both masks. After reset, `irq_out` is 0 and offsets 0x50, 0x57 and 0x71 read 0x00.
- R2: A rising edge on `chan_irq[n]` sets channel n's flag at the clock edge that samples it. The flag then reads 1 at offset 0x71: bit 2 for channel 0, bit 3 for channel 1.
- R3: A falling edge on `chan_irq[n]` clears channel n's flag at the clock edge that samples it.
- R4: A channel line that stays high does not set its flag again after the flag has been cleared. Only a new rising edge sets it.
- R5: Offset 0x50 bit 2 always equals the channel 0 flag, and offset 0x57 bit 4 always equals the channel 1 flag. All other bits of 0x50 and 0x57 read 0.
- R6: An enabled write to 0x71 clears the channel 0 flag where data bit 2 is 1, and the channel 1 flag where data bit 3 is 1. The cleared flag reads 0 at both of its offsets.
- R7: An enabled write to 0x50 with data bit 2 set clears the channel 0 flag. An enabled write to 0x57 with data bit 4 set clears the channel 1 flag. All other data bits have no effect.
- R8: A write with `cfg_be` = 0, or a write to any offset other than 0x50, 0x57 or 0x71, changes no state. Unmodelled offsets read 0x00.
- R9: If a rising edge and a clear of the same channel occur in the same cycle, the flag ends up set.
- R10: A `mask_wr` pulse loads `mask_wdata` into the masks (bit 0 blocks channel 0, bit 1 blocks channel 1). The masks read at 0x71 bits 4 and 5. Configuration writes never change them.
- R11: `irq_out` = (flag0 AND NOT mask0) OR (flag1 AND NOT mask1), evaluated combinationally from the current flags and masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 1 | Byte enable qualifying the write |
| cfg_addr | input | 8 | Configuration byte offset (write and read) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, combinational from `cfg_addr` |
| mask_wr | input | 1 | Mask load strobe |
| mask_wdata | input | 2 | Block mask value, bit n for channel n |
| chan_irq | input | 2 | Channel interrupt levels, bit n for channel n |
| irq_out | output | 1 | Merged level interrupt |

## Verification
Channel edges, clearing writes and mask loads each take effect at the single clock edge that samples them. From just after that edge, the new flags and masks appear on `cfg_rdata` and `irq_out`, since both are combinational from the registers. The bench therefore drives stimulus on the falling edge and samples 1 ns after the next rising edge, with no further wait. Reads are combinational, so the bench changes `cfg_addr` and samples 1 ns later, while no write is pending.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NUM_CH = 2;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CH0_STAT = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_CH1_STAT = 8'h57;
    localparam logic [ADDR_W-1:0] OFS_MODE     = 8'h71;

    localparam int BIT_CH0_STAT = 2;   // flag bit in 0x50
    localparam int BIT_CH1_STAT = 4;   // flag bit in 0x57
    localparam int BIT_MODE_FLG = 2;   // flags at 0x71 bits 3:2
    localparam int BIT_MODE_BLK = 4;   // masks at 0x71 bits 5:4

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } chan_state_e;
endpackage

// File: rtl/irq_chan_fsm.sv
module irq_chan_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl_in,
    input  logic clr_req,
    output logic pending
);
    chan_state_e state_q, state_d;
    logic        lvl_q;
    logic        rise, fall;

    assign rise = lvl_in & ~lvl_q;
    assign fall = ~lvl_in & lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_in;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (rise) state_d = CH_PEND;                  // SET
            CH_PEND: begin
                if (rise)                state_d = CH_PEND;        // SET wins
                else if (fall || clr_req) state_d = CH_IDLE;       // DROP / CLEAR
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == CH_PEND);
    end

    AST_RISE_SETS:   assert property (@(posedge clk) disable iff (rst) rise |=> pending);                      // R2
    AST_FALL_DROPS:  assert property (@(posedge clk) disable iff (rst) fall |=> !pending);                     // R3
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst) (clr_req && !rise) |=> !pending);       // R6
    AST_SET_WINS:    assert property (@(posedge clk) disable iff (rst) (clr_req && rise) |=> pending);         // R9
    AST_NO_REFIRE:   assert property (@(posedge clk) disable iff (rst) (!rise && !fall && !clr_req) |=> $stable(pending)); // R4
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_be,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [NUM_CH-1:0] flags,
    input  logic              mask_wr,
    input  logic [NUM_CH-1:0] mask_wdata,
    output logic [NUM_CH-1:0] clr_req,
    output logic [NUM_CH-1:0] mask,
    output logic [DATA_W-1:0] cfg_rdata
);
    logic wr_en;
    assign wr_en = cfg_wr & cfg_be;

    always_ff @(posedge clk) begin
        if (rst)          mask <= '0;
        else if (mask_wr) mask <= mask_wdata;
    end

    always_comb begin
        clr_req = '0;
        if (wr_en) begin
            unique case (cfg_addr)
                OFS_CH0_STAT: clr_req[0] = cfg_wdata[BIT_CH0_STAT];
                OFS_CH1_STAT: clr_req[1] = cfg_wdata[BIT_CH1_STAT];
                OFS_MODE:     clr_req    = cfg_wdata[BIT_MODE_FLG +: NUM_CH];
                default:      clr_req    = '0;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            OFS_CH0_STAT: cfg_rdata[BIT_CH0_STAT] = flags[0];
            OFS_CH1_STAT: cfg_rdata[BIT_CH1_STAT] = flags[1];
            OFS_MODE: begin
                cfg_rdata[BIT_MODE_FLG +: NUM_CH] = flags;
                cfg_rdata[BIT_MODE_BLK +: NUM_CH] = mask;
            end
            default: cfg_rdata = '0;
        endcase
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst) !mask_wr |=> $stable(mask));              // R10
    AST_NO_STRAY:  assert property (@(posedge clk) disable iff (rst) !(wr_en) |-> (clr_req == '0));            // R8
    AST_MIRROR0:   assert property (@(posedge clk) disable iff (rst) (cfg_addr == OFS_CH0_STAT) |-> (cfg_rdata[BIT_CH0_STAT] == flags[0])); // R5
    AST_MIRROR1:   assert property (@(posedge clk) disable iff (rst) (cfg_addr == OFS_CH1_STAT) |-> (cfg_rdata[BIT_CH1_STAT] == flags[1])); // R5
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_be,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              mask_wr,
    input  logic [NUM_CH-1:0] mask_wdata,
    input  logic [NUM_CH-1:0] chan_irq,
    output logic              irq_out
);
    logic [NUM_CH-1:0] flags;
    logic [NUM_CH-1:0] clr_req;
    logic [NUM_CH-1:0] mask;

    irq_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_be     (cfg_be),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .flags      (flags),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .clr_req    (clr_req),
        .mask       (mask),
        .cfg_rdata  (cfg_rdata)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        irq_chan_fsm u_fsm (
            .clk     (clk),
            .rst     (rst),
            .lvl_in  (chan_irq[ch]),
            .clr_req (clr_req[ch]),
            .pending (flags[ch])
        );
    end

    always_comb begin
        irq_out = |(flags & ~mask);
    end

    AST_ALL_BLOCKED: assert property (@(posedge clk) disable iff (rst) (&mask) |-> !irq_out);                   // R11
    AST_NONE_PEND:   assert property (@(posedge clk) disable iff (rst) (flags == '0) |-> !irq_out);             // R11
    AST_OPEN_PEND:   assert property (@(posedge clk) disable iff (rst) ((flags & ~mask) != '0) |-> irq_out);     // R11
endmodule

// File: tb/sim_irq_status_agg.sv
module sim_irq_status_agg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic       cfg_be = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       mask_wr = 1'b0;
    logic [1:0] mask_wdata = 2'b00;
    logic [1:0] chan_irq = 2'b00;
    logic       irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_status_agg u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .chan_irq(chan_irq), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // all three views packed {0x71, 0x57, 0x50}
    task automatic rd_all(output logic [23:0] v);
        logic [7:0] a, b, c;
        rd(8'h50, a);
        rd(8'h57, b);
        rd(8'h71, c);
        v = {c, b, a};
    endtask

    function automatic logic [23:0] exp_all(input logic [1:0] f, input logic [1:0] m);
        logic [7:0] e50, e57, e71;
        e50 = {5'd0, f[0], 2'd0};
        e57 = {3'd0, f[1], 4'd0};
        e71 = {2'd0, m, f, 2'd0};
        return {e71, e57, e50};
    endfunction

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d, input logic be);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_be = be; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_wr = 1'b0; cfg_be = 1'b0;
    endtask

    task automatic load_mask(input logic [1:0] m);
        @(negedge clk);
        mask_wr = 1'b1; mask_wdata = m;
        step();
        mask_wr = 1'b0;
    endtask

    task automatic set_flags(input logic [1:0] f);
        @(negedge clk);
        chan_irq = 2'b00;
        step();
        @(negedge clk);
        chan_irq = f;
        step();
    endtask

    initial begin
        logic [23:0] v;
        logic [7:0]  d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        rd_all(v);
        chk("R1 reads", v, 24'h0);
        chk("R1 irq", irq_out, 0);

        // R2/R5/R10/R11: sweep every flag and mask combination
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 4; f++) begin
                load_mask(m[1:0]);
                set_flags(f[1:0]);
                rd_all(v);
                chk("R2 R5 R10 views", v, exp_all(f[1:0], m[1:0]));
                chk("R11 irq", irq_out, ((f[0] & ~m[0]) | (f[1] & ~m[1])) ? 1 : 0);
            end
        end
        load_mask(2'b00);

        // R3: falling edges drop the flags
        set_flags(2'b11);
        @(negedge clk); chan_irq = 2'b10; step();
        rd_all(v);
        chk("R3 ch0 drop", v, exp_all(2'b10, 2'b00));
        @(negedge clk); chan_irq = 2'b00; step();
        rd_all(v);
        chk("R3 ch1 drop", v, exp_all(2'b00, 2'b00));
        chk("R3 irq", irq_out, 0);

        // R6/R7/R8: clearing-write sweep over all data at each offset
        for (int a = 0; a < 3; a++) begin
            for (int dv = 0; dv < 256; dv++) begin
                logic [7:0] ad;
                logic [1:0] ef;
                ad = (a == 0) ? 8'h50 : (a == 1) ? 8'h57 : 8'h71;
                set_flags(2'b11);
                cfg_write(ad, dv[7:0], 1'b1);
                ef = 2'b11;
                if (a == 0 && dv[2]) ef[0] = 1'b0;
                if (a == 1 && dv[4]) ef[1] = 1'b0;
                if (a == 2) ef = ef & ~dv[3:2];
                rd_all(v);
                if (a == 2) chk("R6 clear via mode", v, exp_all(ef, 2'b00));
                else        chk("R7 clear via mirror", v, exp_all(ef, 2'b00));
                // R4: lines still high, no re-set
                step();
                rd_all(v);
                chk("R4 no refire", v, exp_all(ef, 2'b00));
            end
        end

        // R8: byte enable low, and foreign offsets
        set_flags(2'b11);
        cfg_write(8'h71, 8'hFF, 1'b0);
        rd_all(v);
        chk("R8 be low", v, exp_all(2'b11, 2'b00));
        for (int a = 0; a < 256; a++) begin
            if (a != 'h50 && a != 'h57 && a != 'h71) begin
                cfg_write(a[7:0], 8'hFF, 1'b1);
                rd(a[7:0], d);
                chk("R8 other read", d, 0);
            end
        end
        rd_all(v);
        chk("R8 other writes", v, exp_all(2'b11, 2'b00));

        // R9: rise and clear in the same cycle
        @(negedge clk); chan_irq = 2'b00; step();
        @(negedge clk);
        chan_irq = 2'b01;
        cfg_wr = 1'b1; cfg_be = 1'b1; cfg_addr = 8'h71; cfg_wdata = 8'h0C;
        step();
        cfg_wr = 1'b0; cfg_be = 1'b0;
        rd_all(v);
        chk("R9 set wins", v, exp_all(2'b01, 2'b00));

        // R10: config writes leave masks alone
        load_mask(2'b10);
        cfg_write(8'h71, 8'h30, 1'b1);
        cfg_write(8'h71, 8'h00, 1'b1);
        rd(8'h71, d);
        chk("R10 mask read-only", d[5:4], 2'b10);
        chk("R11 ch0 open", irq_out, 1);

        // R1: reset mid-operation
        @(negedge clk); rst = 1'b1; chan_irq = 2'b00; step();
        @(negedge clk); rst = 1'b0; #1;
        rd_all(v);
        chk("R1 reset again", v, 24'h0);
        chk("R1 irq again", irq_out, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule